// File: doc/BRIEF.md
# Multi-Mode LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB TFT panel: an active-low horizontal sync, an active-low vertical sync, a data-enable strobe, and the current pixel column and line. It runs on the system clock and advances one pixel only in cycles where the pixel clock enable is high. A 3-bit mode code picks one of five fixed timing sets held inside the block. Each set gives an active length, a front porch, a one-pixel sync pulse and a back porch, for both the horizontal and the vertical axis. The two dual-scan codes use the input timing of the low-resolution panel they feed: code 1 gives the same timing as code 5, and code 0 has a timing set of its own.

A small two-state sequencer controls the raster. In ST_HALT the counters are held at zero and every output is idle. The start transition (ST_HALT to ST_SCAN) happens on the first clock edge that sees a legal code with standby low, and it loads that code's timing set. While in ST_SCAN, the reload transition (ST_SCAN to ST_SCAN) happens at the last pixel of the last line. Only there is a new code's timing taken, so a frame never mixes two timings. The stop transition (ST_SCAN to ST_HALT) happens on any clock edge that sees standby high or an illegal code (2 or 3). Pixel data is meant to be launched on the rising clock edge, and all outputs are decoded from registers that update on that edge.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is low, and afterwards until a legal code is present with standby low, hsync_n and vsync_n are 1, de is 0, and x_pos and y_pos are 0. The first clock edge that sees a legal code with standby low starts the raster at column 0, line 0.
- R2: The timing sets, given as active/front porch/sync/back porch, are: code 7: horizontal 800/40/1/216, vertical 480/10/1/35. Code 6: horizontal 640/24/1/136, vertical 480/18/1/27. Code 5: horizontal 480/2/1/43, vertical 272/2/1/12. Code 4: horizontal 480/2/1/43, vertical 640/4/1/8. Code 0: horizontal 400/20/1/108, vertical 240/2/1/20.
- R3: On each line, hsync_n is 0 for exactly one pixel, at column active+front porch. The line is active+front porch+1+back porch pixels long.
- R4: de is 1 exactly when the column is below the horizontal active length and the line is below the vertical active length. de is never 1 while either sync is 0.
- R5: vsync_n is 0 for the whole of line number (vertical active + vertical front porch). It falls and rises only where the column is 0.
- R6: Code 1 produces the same line timing as code 5.
- R7: On the clock edge after an illegal code (2 or 3) is seen, the outputs are idle and x_pos and y_pos are 0. The outputs stay so until a legal code returns, and the raster then restarts at column 0, line 0.
- R8: On the clock edge after standby is seen high, the outputs are idle and x_pos and y_pos are 0. When standby is released, the raster restarts at column 0, line 0.
- R9: A change between legal codes during a frame has no effect until the last pixel of that frame. The next frame then uses the new timing set from its first pixel.
- R10: On a clock edge with pix_ce low, x_pos, y_pos and the outputs derived from them do not change, except on a stop transition.
- R11: x_pos counts the pixels of a line and wraps to 0 after the last one. At that wrap y_pos steps by one. After the last line of a frame, y_pos wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel clock enable; the raster advances one pixel per high cycle |
| mode_code | input | 3 | Timing set select (0,1,4,5,6,7 legal; 2,3 illegal) |
| standby | input | 1 | Stops the raster and idles the outputs while high |
| hsync_n | output | 1 | Horizontal sync, active low, one pixel wide |
| vsync_n | output | 1 | Vertical sync, active low, one line long |
| de | output | 1 | Data enable, high in the active area |
| x_pos | output | 11 | Current column within the line |
| y_pos | output | 11 | Current line within the frame |

## Verification
The hardest case to reach from the ports is the reload at the frame boundary. It needs a whole frame to run, and it must show that a code changed mid-frame leaves the rest of that frame alone. The bench therefore uses the smallest timing set (code 0, 529 by 263 pixels) and switches to code 5 partway down line 100. It checks that the old line length and vertical sync line hold to the end of the frame, and that the very next frame has the new line length and sync position.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int CNT_W    = 11;
    localparam int CODE_W   = 3;
    localparam int SYNC_LEN = 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // one timing set: lengths of each region on both axes
    typedef struct packed {
        cnt_t h_act;
        cnt_t h_fp;
        cnt_t h_bp;
        cnt_t v_act;
        cnt_t v_fp;
        cnt_t v_bp;
    } tset_t;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_t;

endpackage

// File: rtl/lcdt_mode_table.sv
module lcdt_mode_table
    import lcdt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output tset_t             tset,
    output logic              legal
);

    function automatic tset_t mk(input int ha, input int hf, input int hb,
                                 input int va, input int vf, input int vb);
        tset_t t;
        t.h_act = cnt_t'(ha);
        t.h_fp  = cnt_t'(hf);
        t.h_bp  = cnt_t'(hb);
        t.v_act = cnt_t'(va);
        t.v_fp  = cnt_t'(vf);
        t.v_bp  = cnt_t'(vb);
        return t;
    endfunction

    always_comb begin
        legal = 1'b1;
        tset  = '0;
        unique case (code)
            3'd7:       tset = mk(800, 40, 216, 480, 10, 35);
            3'd6:       tset = mk(640, 24, 136, 480, 18, 27);
            3'd5, 3'd1: tset = mk(480,  2,  43, 272,  2, 12);
            3'd4:       tset = mk(480,  2,  43, 640,  4,  8);
            3'd0:       tset = mk(400, 20, 108, 240,  2, 20);
            default:    legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
    parameter int W        = 11,
    parameter int SYNC_LEN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] act_len,
    input  logic [W-1:0] fp_len,
    input  logic [W-1:0] bp_len,
    output logic [W-1:0] pos,
    output logic         at_last,
    output logic         in_active,
    output logic         in_sync
);

    localparam logic [W-1:0] SYNC_V = W'(SYNC_LEN);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] sync_start;
    logic [W-1:0] last_pos;

    assign sync_start = act_len + fp_len;
    assign last_pos   = act_len + fp_len + SYNC_V + bp_len - ONE_V;

    assign at_last   = (pos == last_pos);
    assign in_active = (pos < act_len);
    assign in_sync   = (pos >= sync_start) && (pos < sync_start + SYNC_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clr) begin
            pos <= '0;
        end else if (adv) begin
            pos <= at_last ? '0 : pos + ONE_V;
        end
    end

endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq
    import lcdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  legal,
    input  logic  standby,
    input  logic  frame_end,
    input  tset_t tset_in,
    output logic  running,
    output logic  clr,
    output tset_t tset_q
);

    scan_st_t st, st_nxt;
    logic     load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HALT;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        load   = 1'b0;
        clr    = 1'b0;
        unique case (st)
            ST_HALT: begin
                clr = 1'b1;
                if (legal && !standby) begin
                    st_nxt = ST_SCAN;   // start
                    load   = 1'b1;
                end
            end
            ST_SCAN: begin
                if (standby || !legal) begin
                    st_nxt = ST_HALT;   // stop
                    clr    = 1'b1;
                end else if (frame_end) begin
                    load   = 1'b1;      // reload
                end
            end
            default: st_nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tset_q <= '0;
        end else if (load) begin
            tset_q <= tset_in;
        end
    end

    assign running = (st == ST_SCAN);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic [CODE_W-1:0] mode_code,
    input  logic              standby,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [CNT_W-1:0]  x_pos,
    output logic [CNT_W-1:0]  y_pos
);

    tset_t tset_live;
    tset_t tset_cur;
    logic  legal;
    logic  running;
    logic  clr;
    logic  h_last, v_last;
    logic  h_act, v_act;
    logic  h_syn, v_syn;
    logic  h_adv, v_adv;
    logic  frame_end;

    lcdt_mode_table u_table (
        .code  (mode_code),
        .tset  (tset_live),
        .legal (legal)
    );

    assign h_adv     = running && pix_ce;
    assign v_adv     = h_adv && h_last;
    assign frame_end = v_adv && v_last;

    lcdt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .legal     (legal),
        .standby   (standby),
        .frame_end (frame_end),
        .tset_in   (tset_live),
        .running   (running),
        .clr       (clr),
        .tset_q    (tset_cur)
    );

    lcdt_axis #(.W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (h_adv),
        .act_len   (tset_cur.h_act),
        .fp_len    (tset_cur.h_fp),
        .bp_len    (tset_cur.h_bp),
        .pos       (x_pos),
        .at_last   (h_last),
        .in_active (h_act),
        .in_sync   (h_syn)
    );

    lcdt_axis #(.W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (v_adv),
        .act_len   (tset_cur.v_act),
        .fp_len    (tset_cur.v_fp),
        .bp_len    (tset_cur.v_bp),
        .pos       (y_pos),
        .at_last   (v_last),
        .in_active (v_act),
        .in_sync   (v_syn)
    );

    always_comb begin
        hsync_n = 1'b1;
        vsync_n = 1'b1;
        de      = 1'b0;
        if (running) begin
            hsync_n = !h_syn;
            vsync_n = !v_syn;
            de      = h_act && v_act;
        end
    end

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_ce,
    input logic [2:0]  mode_code,
    input logic        standby,
    input logic        hsync_n,
    input logic        vsync_n,
    input logic        de,
    input logic [10:0] x_pos,
    input logic [10:0] y_pos
);

    logic code_bad;
    assign code_bad = (mode_code == 3'd2) || (mode_code == 3'd3);

    p_hsync_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n && pix_ce) |=> hsync_n);

    p_de_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));

    p_vs_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) || $rose(vsync_n)) |-> (x_pos == 11'd0));

    p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_bad |=> (hsync_n && vsync_n && !de && x_pos == 11'd0 && y_pos == 11'd0));

    p_standby_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (hsync_n && vsync_n && !de && x_pos == 11'd0 && y_pos == 11'd0));

    p_ce_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && !standby && !code_bad) |=> ($stable(x_pos) && $stable(y_pos)));

    p_x_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (x_pos < 11'd1057) && (y_pos < 11'd653));

endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ce    (pix_ce),
    .mode_code (mode_code),
    .standby   (standby),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .de        (de),
    .x_pos     (x_pos),
    .y_pos     (y_pos)
);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic [2:0]  mode_code = 3'd7;
    logic        standby = 1'b1;
    logic        hsync_n, vsync_n, de;
    logic [10:0] x_pos, y_pos;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    lcd_timing_gen u_lcd_timing_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_ce    (pix_ce),
        .mode_code (mode_code),
        .standby   (standby),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .de        (de),
        .x_pos     (x_pos),
        .y_pos     (y_pos)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit idle_now();
        return hsync_n && vsync_n && !de && x_pos == 0 && y_pos == 0;
    endfunction

    // enter a code from halt, then walk one full line
    task automatic t_line(input logic [2:0] code, input int ha, input int hf, input int hb,
                          input string req);
        int  tot = ha + hf + 1 + hb;
        bit  ok  = 1'b1;
        int  bad = -1;
        standby = 1'b1;
        tick(2);
        mode_code = code;
        standby   = 1'b0;
        tick();
        for (int i = 0; i < tot; i++) begin
            if (ok && (x_pos != i || y_pos != 0 || de != (i < ha) ||
                       hsync_n != (i != ha + hf) || !vsync_n)) begin
                ok  = 1'b0;
                bad = i;
            end
            tick();
        end
        chk(ok, req, bad, -1);
        chk(x_pos == 0 && y_pos == 1, "R11 line wrap", int'(y_pos), 1);
    endtask

    task automatic t_reset();
        chk(hsync_n && vsync_n && !de && x_pos == 0 && y_pos == 0, "R1 in reset",
            int'(de), 0);
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk(idle_now(), "R1 halted by standby", int'(x_pos), 0);
        standby = 1'b0;
        tick();
        chk(x_pos == 0 && y_pos == 0 && de, "R1 start at origin", int'(de), 1);
        tick(4);
        chk(x_pos == 4, "R1 counting", int'(x_pos), 4);
    endtask

    task automatic t_standby();
        standby = 1'b1; tick(); standby = 1'b0;
        mode_code = 3'd7;
        tick(51);
        chk(x_pos == 50, "R8 pre", int'(x_pos), 50);
        standby = 1'b1;
        tick();
        chk(idle_now(), "R8 stop", int'(x_pos), 0);
        tick(5);
        chk(idle_now(), "R8 held", int'(x_pos), 0);
        standby = 1'b0;
        tick();
        chk(x_pos == 0 && y_pos == 0 && de, "R8 restart", int'(x_pos), 0);
        tick(3);
        chk(x_pos == 3, "R8 resume", int'(x_pos), 3);
    endtask

    task automatic t_illegal(input logic [2:0] code);
        mode_code = 3'd6;
        tick(20);
        mode_code = code;
        tick();
        chk(idle_now(), "R7 illegal stop", int'(x_pos), 0);
        tick(4);
        chk(idle_now(), "R7 illegal held", int'(x_pos), 0);
        mode_code = 3'd6;
        tick();
        chk(x_pos == 0 && de, "R7 restart", int'(x_pos), 0);
    endtask

    task automatic t_ce();
        int x0;
        mode_code = 3'd6;
        tick(10);
        x0 = int'(x_pos);
        pix_ce = 1'b0;
        tick(3);
        chk(int'(x_pos) == x0, "R10 hold", int'(x_pos), x0);
        pix_ce = 1'b1;
        tick();
        chk(int'(x_pos) == x0 + 1, "R10 resume", int'(x_pos), x0 + 1);
        x0 = int'(x_pos);
        for (int i = 0; i < 10; i++) begin
            pix_ce = i[0];
            tick();
        end
        pix_ce = 1'b1;
        chk(int'(x_pos) == x0 + 5, "R10 half rate", int'(x_pos), x0 + 5);
    endtask

    // full frame of code 0; code switched to 5 on line 100
    task automatic t_frame();
        localparam int HT = 529;
        localparam int VT = 263;
        standby = 1'b1;
        tick(2);
        mode_code = 3'd0;
        standby   = 1'b0;
        tick();
        for (int i = 0; i < HT * VT; i++) begin
            int hh = i % HT;
            int vv = i / HT;
            if (vv == 0 && hh == 0)
                chk(de && x_pos == 0 && y_pos == 0, "R4 first pixel", int'(de), 1);
            if (vv == 241 && hh == 528)
                chk(vsync_n == 1'b1, "R5 before sync line", int'(vsync_n), 1);
            if (vv == 242 && hh == 0)
                chk(vsync_n == 1'b0 && y_pos == 242, "R5 sync line start", int'(vsync_n), 0);
            if (vv == 242 && hh == 528)
                chk(vsync_n == 1'b0, "R5 sync line end", int'(vsync_n), 0);
            if (vv == 243 && hh == 0)
                chk(vsync_n == 1'b1, "R5 after sync line", int'(vsync_n), 1);
            if (vv == 250 && hh == 10)
                chk(!de && hsync_n, "R4 vertical blank", int'(de), 0);
            if (vv == 200 && hh == 420)
                chk(!hsync_n, "R9 old hsync position", int'(hsync_n), 0);
            if (vv == 200 && hh == 528)
                chk(x_pos == 528, "R9 old line length", int'(x_pos), 528);
            if (vv == 100 && hh == 5)
                mode_code = 3'd5;
            tick();
        end
        chk(x_pos == 0 && y_pos == 0 && de, "R9 frame wrap", int'(y_pos), 0);
        tick(482);
        chk(!hsync_n && x_pos == 482, "R9 new hsync position", int'(x_pos), 482);
        tick(44);
        chk(x_pos == 0 && y_pos == 1, "R9 new line length", int'(x_pos), 0);
    endtask

    initial begin
        tick(2);
        t_reset();
        t_line(3'd7, 800, 40, 216, "R2 R3 code 7 line");
        t_line(3'd6, 640, 24, 136, "R2 R3 code 6 line");
        t_line(3'd5, 480, 2, 43,   "R2 R3 code 5 line");
        t_line(3'd4, 480, 2, 43,   "R2 R3 code 4 line");
        t_line(3'd0, 400, 20, 108, "R2 R3 code 0 line");
        t_line(3'd1, 480, 2, 43,   "R6 code 1 alias");
        t_standby();
        t_illegal(3'd2);
        t_illegal(3'd3);
        t_ce();
        t_frame();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule